// File: doc/BRIEF.md
# Keyboard Scan Code Port

This block is the host-facing report port of a keyboard controller. Key events come in on a simple event interface: a strobe, a 7-bit key index that gives the physical position of the key, and a flag that tells a press from a release. Each event is packed into one byte and held in a register. A host on a small register bus reads that byte through an 8-bit input port at a fixed address.

The low seven bits of the byte are the position code. It has no relation to any character code, and translation is left to host software. The top bit is the key state. A polling host waits until that bit goes low, reads the code, and then waits until the bit goes high again before it accepts another key. Presses and releases are both reported. A byte stays in place until the next event replaces it. Reading the port never changes it.

Top module: `kbd_scan_port`

## Requirements
- R1: While reset is high, and after reset until the first event, the port reads 0x80: status bit set (released) and code 0.
- R2: Bits 6..0 of the byte read from the port equal the 7-bit key index of the most recent event.
- R3: Bit 7 of the byte read from the port is 0 when the most recent event was a press (release flag 0) and 1 when it was a release (release flag 1).
- R4: An event strobed in cycle N becomes visible on the port in cycle N+1. A read in cycle N itself still returns the previous byte.
- R5: Without an event strobe, the held byte keeps its value for any number of cycles.
- R6: A read has no side effect: repeated reads return the same byte until an event arrives.
- R7: bus_oe is high only when bus_cs and bus_rd are both high and bus_addr equals the port address, which is 0x60 by default. While bus_oe is low, bus_rdata is 0.
- R8: A press and the following release of the same key each produce a report, so the byte changes from {0,code} to {1,code}. Back-to-back events on consecutive cycles each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Key event strobe, one cycle per event |
| evt_key | input | 7 | Position-based key index |
| evt_release | input | 1 | 1 = key released, 0 = key pressed |
| bus_cs | input | 1 | Host chip select |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 8 | Host port address |
| bus_rdata | output | 8 | Read data, 0 when not driven |
| bus_oe | output | 1 | Read-data output enable (tri-state gate model) |

## Verification
The key input is driven with a mid-range index, with all-zeros and all-ones indices, and with alternating press and release flags. This shows whether the code bits and the status bit travel independently to the right positions. Events that arrive in the same cycle as a read, and events on consecutive cycles, separate one-cycle latching from a latch that is combinational or late. Long runs of reads with no event, and reads with a wrong address, with chip select low or with the read strobe low, separate a side-effect-free, correctly decoded port from one that disturbs or leaks the held byte.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

    localparam int CODE_W   = 7;
    localparam int REPORT_W = CODE_W + 1;

    typedef struct packed {
        logic              released;
        logic [CODE_W-1:0] code;
    } key_report_t;

    localparam key_report_t REPORT_IDLE = '{released: 1'b1, code: '0};

    function automatic key_report_t make_report(
        input logic [CODE_W-1:0] key_idx,
        input logic              up
    );
        key_report_t r;
        r.released = up;
        r.code     = key_idx;
        return r;
    endfunction

endpackage

// File: rtl/kbd_event_latch.sv
module kbd_event_latch
    import kbd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_key,
    input  logic              evt_release,
    output key_report_t       held
);

    key_report_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= REPORT_IDLE;
        end else if (evt_valid) begin
            held_q <= make_report(evt_key, evt_release);
        end
    end

    assign held = held_q;

endmodule

// File: rtl/kbd_port_decode.sv
module kbd_port_decode #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h60
) (
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              sel
);

    logic addr_hit;

    always_comb begin
        addr_hit = (bus_addr == PORT_ADDR);
        sel      = bus_cs & bus_rd & addr_hit;
    end

endmodule

// File: rtl/kbd_read_gate.sv
module kbd_read_gate #(
    parameter int WIDTH = 8
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             oe
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign dout[b] = din[b] & sel;
    end

    assign oe = sel;

endmodule

// File: rtl/kbd_scan_port.sv
module kbd_scan_port
    import kbd_port_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h60
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_valid,
    input  logic [CODE_W-1:0]   evt_key,
    input  logic                evt_release,
    input  logic                bus_cs,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [REPORT_W-1:0] bus_rdata,
    output logic                bus_oe
);

    key_report_t         held;
    logic [REPORT_W-1:0] held_byte;
    logic                port_sel;

    kbd_event_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .evt_valid   (evt_valid),
        .evt_key     (evt_key),
        .evt_release (evt_release),
        .held        (held)
    );

    assign held_byte = held;

    kbd_port_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .bus_cs   (bus_cs),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .sel      (port_sel)
    );

    kbd_read_gate #(
        .WIDTH (REPORT_W)
    ) u_gate (
        .sel  (port_sel),
        .din  (held_byte),
        .dout (bus_rdata),
        .oe   (bus_oe)
    );

endmodule

// File: rtl/kbd_scan_port_chk.sv
module kbd_scan_port_chk
    import kbd_port_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h60
) (
    input logic                clk,
    input logic                rst,
    input logic                evt_valid,
    input logic [CODE_W-1:0]   evt_key,
    input logic                evt_release,
    input logic                bus_cs,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [REPORT_W-1:0] bus_rdata,
    input logic                bus_oe,
    input logic [REPORT_W-1:0] held_byte
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (held_byte == {1'b1, {CODE_W{1'b0}}}));

    assert_event_next_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> (held_byte == {$past(evt_release), $past(evt_key)}));

    assert_hold_without_event_R5: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |=> $stable(held_byte));

    assert_read_shows_held_R2: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (bus_rdata == held_byte));

    assert_no_strobe_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs || !bus_rd || (bus_addr != PORT_ADDR)) |-> (!bus_oe && (bus_rdata == '0)));

endmodule

bind kbd_scan_port kbd_scan_port_chk #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_valid   (evt_valid),
    .evt_key     (evt_key),
    .evt_release (evt_release),
    .bus_cs      (bus_cs),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_oe      (bus_oe),
    .held_byte   (held_byte)
);

// File: tb/kbd_scan_port_tb.sv
module kbd_scan_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_valid = 1'b0;
    logic [6:0] evt_key = '0;
    logic       evt_release = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_rdata;
    logic       bus_oe;

    int    total = 0;
    int    bad = 0;
    int    exp_held = 'h80;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    kbd_scan_port u_dut (
        .clk         (clk),
        .rst         (rst),
        .evt_valid   (evt_valid),
        .evt_key     (evt_key),
        .evt_release (evt_release),
        .bus_cs      (bus_cs),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_rdata   (bus_rdata),
        .bus_oe      (bus_oe)
    );

    // Reference model: the byte the port should hold
    always @(posedge clk) begin
        if (rst) exp_held <= 'h80;
        else if (evt_valid) exp_held <= (int'(evt_release) << 7) | int'(evt_key);
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            bit exp_oe;
            int exp_data;
            exp_oe   = bus_cs && bus_rd && (bus_addr == 8'h60);
            exp_data = exp_oe ? exp_held : 0;
            total++;
            if (bus_oe !== exp_oe || int'(bus_rdata) != exp_data || $isunknown(bus_rdata)) begin
                bad++;
                $display("FAIL %s: oe=%0b rdata=%02h expected oe=%0b rdata=%02h",
                         cur_req, bus_oe, bus_rdata, exp_oe, exp_data[7:0]);
            end
        end
    end

    task automatic drive(input bit cs, input bit rd, input logic [7:0] addr,
                         input bit ev, input logic [6:0] key, input bit rel);
        @(negedge clk);
        #1;
        bus_cs = cs; bus_rd = rd; bus_addr = addr;
        evt_valid = ev; evt_key = key; evt_release = rel;
    endtask

    task automatic rd_port();
        drive(1, 1, 8'h60, 0, 7'h00, 0);
    endtask

    task automatic event_only(input logic [6:0] key, input bit rel);
        drive(0, 0, 8'h00, 1, key, rel);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        checking = 1'b1;
        // R1: reads during and after reset return 0x80
        cur_req = "R1";
        drive(1, 1, 8'h60, 1, 7'h2A, 0);
        rd_port();
        drive(1, 1, 8'h60, 0, 7'h00, 0);
        rst = 1'b0;
        rd_port();
        rd_port();

        // R2, R3: press of a mid-range key, then read
        cur_req = "R3";
        event_only(7'h15, 0);
        rd_port();
        rd_port();

        // R8: release of the same key
        cur_req = "R8";
        event_only(7'h15, 1);
        rd_port();

        // R4: event in the same cycle as a read; read sees the old byte first
        cur_req = "R4";
        drive(1, 1, 8'h60, 1, 7'h7F, 0);
        rd_port();
        drive(1, 1, 8'h60, 1, 7'h00, 1);
        rd_port();

        // R8: back-to-back events on consecutive cycles, alternating status
        cur_req = "R8";
        for (int i = 0; i < 8; i++) begin
            drive(1, 1, 8'h60, 1, 7'(i * 17 + 3), i[0]);
        end
        rd_port();

        // R2: sweep extreme and patterned key indices
        cur_req = "R2";
        event_only(7'h7F, 1);
        rd_port();
        event_only(7'h55, 0);
        rd_port();
        event_only(7'h2A, 1);
        rd_port();

        // R6: many reads with no event, byte unchanged
        cur_req = "R6";
        for (int i = 0; i < 10; i++) rd_port();

        // R5: long idle stretch with no strobe, then read
        cur_req = "R5";
        for (int i = 0; i < 20; i++) drive(0, 0, 8'h00, 0, 7'h11, 1);
        rd_port();

        // R7: wrong address, chip select low, read strobe low
        cur_req = "R7";
        drive(1, 1, 8'h61, 0, 7'h00, 0);
        drive(1, 1, 8'hE0, 0, 7'h00, 0);
        drive(0, 1, 8'h60, 0, 7'h00, 0);
        drive(1, 0, 8'h60, 0, 7'h00, 0);
        rd_port();

        // R1: reset after activity restores 0x80
        cur_req = "R1";
        event_only(7'h33, 0);
        drive(1, 1, 8'h60, 0, 7'h00, 0);
        rst = 1'b1;
        rd_port();
        drive(1, 1, 8'h60, 0, 7'h00, 0);
        rst = 1'b0;
        rd_port();
        rd_port();

        @(negedge clk);
        #1;
        checking = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule